// File: doc/BRIEF.md
# I2C Slave 16-bit Port Expander

This block is an I2C slave that gives a bus master read and write access to a 16-bit parallel port. A fast system clock samples SCL and SDA. The block never drives SDA high: it pulls the line low through an output-enable, and an external pull-up provides the high level. Three strap inputs set the low bits of the 7-bit slave address.

A write transfer carries two data bytes. The first byte sets the low half of the port output latch and the second sets the high half. A read transfer returns the sampled port inputs, low byte first, and keeps alternating between the two halves for as long as the master acknowledges. The latch changes only when a byte has been received in full and acknowledged. A byte cut short by a START or a STOP leaves the port untouched.

Top module: `i2c_port_expander`

## Requirements
- R1: After reset, `port_o` is 0 and `sda_oe` is 0, so SDA is released.
- R2: The first byte after a START is taken most significant bit first. Bits 7..1 are the slave address and bit 0 is R/W, where 1 means read. The slave address is binary 0100 followed by the straps in the order A2 A1 A0. On a match the block holds `sda_oe` at 1 through the whole ninth clock.
- R3: A byte that does not match the slave address gets no acknowledge. This includes the general call address 0000000. `sda_oe` then stays 0 for every later clock until the next START.
- R4: The straps are sampled at START. A change to them after the START does not affect address matching in that transfer.
- R5: In a write, the first data byte goes to `port_o[7:0]` and the second to `port_o[15:8]`. The block acknowledges each of them.
- R6: Data bytes after the second in a write are acknowledged and leave `port_o` unchanged.
- R7: `port_o` changes only at the rising SCL edge of the acknowledge clock of a complete byte. A byte interrupted by a STOP or a repeated START changes nothing.
- R8: In a read, the block sends `port_i[7:0]` first, then `port_i[15:8]`, then the pair again while the master acknowledges. Bits go out most significant bit first, and SDA changes only while SCL is low.
- R9: The port inputs for each read byte are captured at the rising SCL edge of the acknowledge clock that precedes that byte.
- R10: A NACK from the master after a read byte ends the transfer. `sda_oe` then stays 0 until the next START.
- R11: SCL and SDA each pass through a two-flop synchronizer and a 3-sample filter. A pulse that lasts 2 system clocks or less is ignored: it counts as no clock edge and as no START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data level as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_i | input | 3 | Low address bits A2 A1 A0 |
| port_i | input | 16 | Sampled port pin values |
| port_o | output | 16 | Port output latch |

## Verification
The bench attacks bytes that are aborted partway through, with both a STOP and a repeated START. A design that latched bits as they arrived would corrupt half of the port there. It sends a mismatched address and the general call address. A design that decoded too loosely would pull SDA low and block the bus. It changes `port_i` and the straps in the middle of a transfer to pin down the exact capture points: a design that sampled late would return the new value instead of the one it held at the acknowledge. Short pulses on SCL and SDA probe the filter. Without the filter, the design would count an extra bit or see a false START and shift every byte that followed.

// File: rtl/i2c_port_expander.sv
module i2c_port_expander #(
  parameter logic [3:0] ADDR_HI = 4'b0100,
  parameter int         FILT    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  strap_i,
  input  logic [15:0] port_i,
  output logic [15:0] port_o
);

  typedef enum logic [1:0] {IDLE, ADDR, WR, RD} st_t;

  st_t             st;
  logic [1:0]      scl_s, sda_s;
  logic [FILT-1:0] scl_h, sda_h;
  logic            scl_f, sda_f, scl_d, sda_d;
  logic [3:0]      bitcnt;
  logic [7:0]      sr;
  logic [2:0]      strap_q;
  logic            rw, rd_hi;
  logic [1:0]      wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
      scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[FILT-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT-2:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  wire start_c = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_c  = scl_f & scl_d & ~sda_d & sda_f;
  wire rise    = scl_f & ~scl_d;
  wire fall    = ~scl_f & scl_d;
  wire addr_ok = (sr[7:1] == {ADDR_HI, strap_q}) && (sr[7:1] != 7'd0);
  wire reading = (st == RD) || (st == ADDR && rw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; bitcnt <= '0; sr <= '0; strap_q <= '0;
      rw <= 1'b0; rd_hi <= 1'b0; wcnt <= '0;
      sda_oe <= 1'b0; port_o <= '0;
    end else if (start_c) begin
      st <= ADDR; bitcnt <= '0; strap_q <= strap_i;
      sda_oe <= 1'b0; wcnt <= '0; rw <= 1'b0;
    end else if (stop_c) begin
      st <= IDLE; sda_oe <= 1'b0;
    end else if (st != IDLE) begin
      if (rise) begin
        if (bitcnt < 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
          if (st != RD) sr <= {sr[6:0], sda_f};
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          case (st)
            ADDR: if (rw) begin sr <= port_i[7:0]; rd_hi <= 1'b1; end
            WR: begin
              if (wcnt == 2'd0) port_o[7:0] <= sr;
              else if (wcnt == 2'd1) port_o[15:8] <= sr;
              if (wcnt != 2'd2) wcnt <= wcnt + 2'd1;
            end
            RD: if (sda_f) st <= IDLE;
                else begin
                  sr <= rd_hi ? port_i[15:8] : port_i[7:0];
                  rd_hi <= ~rd_hi;
                end
            default: ;
          endcase
        end
      end else if (fall) begin
        if (bitcnt == 4'd8) begin
          if (st == ADDR) begin
            if (addr_ok) begin sda_oe <= 1'b1; rw <= sr[0]; end
            else st <= IDLE;
          end else sda_oe <= (st == WR);
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (st == ADDR) st <= rw ? RD : WR;
          sda_oe <= reading ? ~sr[7] : 1'b0;
        end else if (st == RD && bitcnt != 4'd0) begin
          sda_oe <= ~sr[6];
          sr <= {sr[6:0], 1'b0};
        end
      end
    end
  end

  a_r8_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f);
  a_r7_port_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_o) |-> (scl_f && $past(st) == WR && $past(bitcnt) == 4'd8));
  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE) |-> !sda_oe);
  a_r2_ack_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && st != RD) |-> (bitcnt >= 4'd8));
  a_r10_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == RD && st == IDLE) |-> !sda_oe);

endmodule

// File: tb/test_i2c_port_expander.sv
module test_i2c_port_expander;
  localparam int Q = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1, msda = 1'b1;
  logic        sda_oe;
  logic [2:0]  strap = 3'b101;
  logic [15:0] port_in = 16'hBEEF;
  logic [15:0] port_o;
  logic        sda_line;
  logic [15:0] exp_port = 16'h0;
  int          errors = 0, checks = 0, quiet = 0;
  logic        run = 1'b0, prev_scl = 1'b1, prev_sda = 1'b1;

  assign sda_line = msda & ~sda_oe;

  always #5 clk = ~clk;

  i2c_port_expander i_i2c_port_expander (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .port_i(port_in), .port_o(port_o));

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (scl != prev_scl || sda_line != prev_sda) quiet <= 0;
    else quiet <= quiet + 1;
    prev_scl <= scl; prev_sda <= sda_line;
    if (run && quiet == 10) chk(port_o == exp_port, "R7 port model", port_o, exp_port);
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic tx, input int glitch, output logic l1, output logic l2, output logic oe);
    msda = tx;
    if (glitch == 1) begin
      wait_cyc(Q); scl = 1'b1; wait_cyc(2); scl = 1'b0; wait_cyc(Q - 2);
    end else wait_cyc(2*Q);
    scl = 1'b1;
    if (glitch == 2) begin
      wait_cyc(5); msda = 1'b0; wait_cyc(2); msda = tx; wait_cyc(Q - 7);
    end else wait_cyc(Q);
    l1 = sda_line; oe = sda_oe;
    wait_cyc(Q - 1);
    l2 = sda_line;
    wait_cyc(1);
    scl = 1'b0;
  endtask

  task automatic start_c;
    msda = 1'b1; wait_cyc(Q); scl = 1'b1; wait_cyc(2*Q);
    msda = 1'b0; wait_cyc(2*Q); scl = 1'b0; wait_cyc(Q);
  endtask

  task automatic stop_c;
    msda = 1'b0; wait_cyc(Q); scl = 1'b1; wait_cyc(2*Q);
    msda = 1'b1; wait_cyc(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req,
                           input bit upd, input logic [15:0] nexp, input int gbit, input int gkind);
    logic l1, l2, oe;
    for (int i = 7; i >= 0; i--) begin
      bitx(b[i], (i == gbit) ? gkind : 0, l1, l2, oe);
      chk(oe == 1'b0, req, {15'd0, oe}, 16'd0);
    end
    msda = 1'b1; wait_cyc(2*Q);
    scl = 1'b1;
    if (upd) exp_port = nexp;
    wait_cyc(Q);
    chk(sda_oe == exp_ack, req, {15'd0, sda_oe}, {15'd0, exp_ack});
    wait_cyc(Q);
    scl = 1'b0;
  endtask

  task automatic recv_byte(input logic [7:0] eb, input logic mack, input string req);
    logic l1, l2, oe;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      bitx(1'b1, 0, l1, l2, oe);
      got[i] = l1;
      chk(l1 == l2, "R8 stable while SCL high", {15'd0, l2}, {15'd0, l1});
    end
    chk(got == eb, req, {8'd0, got}, {8'd0, eb});
    bitx(~mack, 0, l1, l2, oe);
    chk(oe == 1'b0, "R8 released for master ack", {15'd0, oe}, 16'd0);
  endtask

  task automatic partial(input logic [7:0] b, input int n);
    logic l1, l2, oe;
    for (int i = 7; i > 7 - n; i--) bitx(b[i], 0, l1, l2, oe);
  endtask

  initial begin
    logic l1, l2, oe;
    wait_cyc(5);
    chk(port_o == 16'h0, "R1 port reset", port_o, 16'h0);
    chk(sda_oe == 1'b0, "R1 sda released", {15'd0, sda_oe}, 16'd0);
    rst_n = 1'b1;
    wait_cyc(20);
    run = 1'b1;

    // R2 R5 R6
    start_c;
    send_byte(8'h4A, 1'b1, "R2 address ack", 0, 16'h0, -1, 0);
    send_byte(8'hA5, 1'b1, "R5 low byte", 1, 16'h00A5, -1, 0);
    send_byte(8'h3C, 1'b1, "R5 high byte", 1, 16'h3CA5, -1, 0);
    send_byte(8'hFF, 1'b1, "R6 extra byte acked", 0, 16'h0, -1, 0);
    stop_c;
    chk(port_o == 16'h3CA5, "R6 extra byte ignored", port_o, 16'h3CA5);

    // R3 mismatch and general call
    start_c;
    send_byte(8'h40, 1'b0, "R3 wrong address nack", 0, 16'h0, -1, 0);
    send_byte(8'h00, 1'b0, "R3 silent after mismatch", 0, 16'h0, -1, 0);
    stop_c;
    start_c;
    send_byte(8'h00, 1'b0, "R3 general call nack", 0, 16'h0, -1, 0);
    send_byte(8'h12, 1'b0, "R3 silent after general call", 0, 16'h0, -1, 0);
    stop_c;
    chk(port_o == 16'h3CA5, "R3 port unchanged", port_o, 16'h3CA5);

    // R4 straps sampled at START
    start_c;
    strap = 3'b000;
    send_byte(8'h4A, 1'b1, "R4 straps held", 0, 16'h0, -1, 0);
    send_byte(8'h5A, 1'b1, "R4 write", 1, 16'h3C5A, -1, 0);
    send_byte(8'h6B, 1'b1, "R4 write", 1, 16'h6B5A, -1, 0);
    stop_c;
    start_c;
    send_byte(8'h4A, 1'b0, "R4 new strap value", 0, 16'h0, -1, 0);
    stop_c;
    strap = 3'b101;

    // R7 aborted bytes
    start_c;
    send_byte(8'h4A, 1'b1, "R7 address", 0, 16'h0, -1, 0);
    send_byte(8'h11, 1'b1, "R7 full byte", 1, 16'h6B11, -1, 0);
    partial(8'h99, 4);
    stop_c;
    chk(port_o == 16'h6B11, "R7 stop mid byte", port_o, 16'h6B11);
    start_c;
    send_byte(8'h4A, 1'b1, "R7 address", 0, 16'h0, -1, 0);
    partial(8'h77, 3);
    start_c;
    send_byte(8'h4A, 1'b1, "R7 restart address", 0, 16'h0, -1, 0);
    send_byte(8'h22, 1'b1, "R7 after restart", 1, 16'h6B22, -1, 0);
    stop_c;
    chk(port_o == 16'h6B22, "R7 restart mid byte", port_o, 16'h6B22);

    // R8 R10 read
    port_in = 16'hBEEF;
    start_c;
    send_byte(8'h4B, 1'b1, "R2 read address ack", 0, 16'h0, -1, 0);
    recv_byte(8'hEF, 1'b1, "R8 low byte first");
    recv_byte(8'hBE, 1'b1, "R8 high byte second");
    recv_byte(8'hEF, 1'b0, "R8 pair repeats");
    bitx(1'b1, 0, l1, l2, oe);
    chk(oe == 1'b0, "R10 released after nack", {15'd0, oe}, 16'd0);
    bitx(1'b1, 0, l1, l2, oe);
    chk(oe == 1'b0, "R10 still released", {15'd0, oe}, 16'd0);
    stop_c;

    // R9 capture point
    port_in = 16'hBEEF;
    start_c;
    send_byte(8'h4B, 1'b1, "R9 read address", 0, 16'h0, -1, 0);
    port_in = 16'h1234;
    recv_byte(8'hEF, 1'b1, "R9 captured at address ack");
    recv_byte(8'h12, 1'b1, "R9 captured at first ack");
    port_in = 16'h5678;
    recv_byte(8'h34, 1'b0, "R9 captured at second ack");
    stop_c;

    // R11 glitch filter
    start_c;
    send_byte(8'h4A, 1'b1, "R11 address", 0, 16'h0, -1, 0);
    send_byte(8'hC3, 1'b1, "R11 scl glitch", 1, 16'h6BC3, 3, 1);
    send_byte(8'h0F, 1'b1, "R11 sda glitch", 1, 16'h0FC3, 1, 2);
    stop_c;
    chk(port_o == 16'h0FC3, "R11 filtered transfer", port_o, 16'h0FC3);

    wait_cyc(20);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule